// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block supplies the word address of a synchronous burst memory array on every clock. An external address is captured when a burst begins. After that the block walks the two least significant address bits through a four-word burst by itself, one step per clock edge on which the advance strobe is high. The upper address bits stay as they were loaded.

A burst can begin from either of two start strobes, one from the processor side and one from the memory controller side. A run-time mode input chooses the counting order. The low level gives linear order, which adds one modulo four. The high level gives interleaved order, which XORs the loaded low bits with a two-bit step count. Interleaved is the level intended when the mode pin is left unconnected. A caller that has no use for bursts can assert a start strobe on every cycle and load a new address each clock at no cost in cycles.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `word_addr` is all zeros.
- R2: On a rising edge where `start_cpu` or `start_ctl` is high, `addr_in` is loaded, and from that edge `word_addr` equals the loaded address.
- R3: When both start strobes are high on the same edge, the processor-side strobe wins. The address is loaded once and the step count restarts at zero.
- R4: With `ilv_mode` = 0, every advance edge raises `word_addr[1:0]` by one modulo 4. A start at 3 gives 3,0,1,2.
- R5: With `ilv_mode` = 1, `word_addr[1:0]` is the loaded low bits XOR the step count. The step count rises by one on each advance edge. A start at 1 gives 1,0,3,2.
- R6: On an edge with no start strobe and no advance, `word_addr` holds its value, provided `ilv_mode` is unchanged.
- R7: Advancing never changes `word_addr[ADDR_W-1:2]`. A wrap of the low bits carries nothing upward.
- R8: A start strobe overrides `adv` on the same edge. The new address is loaded, and no step is taken.
- R9: A start strobe held high on consecutive edges loads a new address on each of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External address loaded at a burst start |
| start_cpu | input | 1 | Processor-side burst start, higher priority |
| start_ctl | input | 1 | Controller-side burst start |
| adv | input | 1 | Advance the burst by one word |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| word_addr | output | ADDR_W | Current array word address |

## Verification
The bench aims at the places where the two orders differ, for example the interleaved start of 1. A design that simply added one in both modes would present 1,2,3,0 there instead of 1,0,3,2. It also runs the linear wrap from 3 to 0, where a full-width adder would wrongly increment bit 2. Two further cases are both strobes together and a start arriving together with advance. A design that stepped on those edges, or left the step count unreset, would show an offset low address on the cycle that follows. Random traffic also switches the mode in the middle of a burst and checks that the current order is applied to the saved start address and step count.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              adv,
  input  logic              ilv_mode,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic              load;
  logic [1:0]        low_lin, low_ilv;

  // processor-side strobe has priority; both sources load the same address
  assign load = start_cpu ? 1'b1 : start_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      step_q <= '0;
    end else if (adv) begin
      step_q <= step_q + 2'd1;
    end
  end

  assign low_lin   = base_q[1:0] + step_q;
  assign low_ilv   = base_q[1:0] ^ step_q;
  assign word_addr = {base_q[ADDR_W-1:2], ilv_mode ? low_ilv : low_lin};

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              start_cpu,
  input logic              start_ctl,
  input logic              adv,
  input logic              ilv_mode,
  input logic [ADDR_W-1:0] word_addr
);
  logic started;
  always_ff @(posedge clk) started <= rst_n;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> word_addr == '0);

  // R8: the load is exact even with adv high
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cpu || start_ctl) |=> word_addr == $past(addr_in));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || !started)
    (!start_cpu && !start_ctl && !adv) |=> (!$stable(ilv_mode) || $stable(word_addr)));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n || !started)
    (adv && !start_cpu && !start_ctl && !ilv_mode) |=>
      (ilv_mode || word_addr[1:0] == $past(word_addr[1:0]) + 2'd1));

  assert_upper_stable_R7: assert property (@(posedge clk) disable iff (!rst_n || !started)
    (adv && !start_cpu && !start_ctl) |=> $stable(word_addr[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int W = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] addr_in = '0;
  logic start_cpu = 0, start_ctl = 0, adv = 0, ilv_mode = 1;
  logic [W-1:0] word_addr;

  int checks = 0, errors = 0;
  int m_base = 0, m_step = 0;
  string tag = "R1";

  burst_addr_gen #(.ADDR_W(W)) u_dut (.*);

  always #4 clk = ~clk;

  // behavioural reference: loaded address plus a step count
  always @(posedge clk) begin
    if (!rst_n) begin m_base = 0; m_step = 0; tag = "R1"; end
    else if (start_cpu || start_ctl) begin
      m_base = int'(addr_in); m_step = 0;
      tag = (start_cpu && start_ctl) ? "R3" : (adv ? "R8" : "R2");
    end else if (adv) begin
      m_step = (m_step + 1) % 4; tag = ilv_mode ? "R5" : "R4";
    end else tag = "R6";
  end

  function automatic int model_out();
    int lo;
    lo = ilv_mode ? ((m_base & 3) ^ m_step) : (((m_base & 3) + m_step) % 4);
    return (m_base & ~3) | lo;
  endfunction

  task automatic chk(string t, int exp);
    checks++;
    if (int'(word_addr) != exp) begin
      errors++;
      $display("FAIL %s: word_addr=%0h expected %0h", t, word_addr, exp);
    end
  endtask

  task automatic cyc(logic sc, logic st, logic a, logic [W-1:0] ad);
    start_cpu = sc; start_ctl = st; adv = a; addr_in = ad;
    @(negedge clk);
    chk(tag, model_out());
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 0);
    rst_n = 1;
    @(negedge clk); chk("R1", 0);

    // R5 interleaved from 1: 1,0,3,2
    ilv_mode = 1;
    cyc(1, 0, 0, 20'h12341); chk("R5", 'h12341);
    cyc(0, 0, 1, '0); chk("R5", 'h12340);
    cyc(0, 0, 1, '0); chk("R5", 'h12343);
    cyc(0, 0, 0, '0); chk("R6", 'h12343);
    cyc(0, 0, 1, '0); chk("R5", 'h12342);

    // R4 / R7 linear from 3: 3,0,1,2, upper bits unchanged
    ilv_mode = 0;
    cyc(0, 1, 0, 20'hABCD3); chk("R2", 'hABCD3);
    cyc(0, 0, 1, '0); chk("R7", 'hABCD0);
    cyc(0, 0, 1, '0); chk("R4", 'hABCD1);
    cyc(0, 0, 1, '0); chk("R4", 'hABCD2);

    // R3 both strobes, R8 start with advance
    cyc(1, 1, 1, 20'h00F02); chk("R3", 'h00F02);
    cyc(0, 0, 1, '0); chk("R4", 'h00F03);
    cyc(0, 1, 1, 20'h55555); chk("R8", 'h55555);

    // R9 back-to-back loads
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 0, W'(i * 37 + 5));
      chk("R9", i * 37 + 5);
    end

    // random traffic with mode switching
    for (int i = 0; i < 2000; i++) begin
      ilv_mode = ($urandom % 5) == 0 ? ~ilv_mode : ilv_mode;
      cyc(($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2, W'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule